// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock

This block sits between the filtered command bits of one inverter leg and the two gate-enable outputs of that leg. One output drives the high-side switch and the other drives the low-side switch. Both outputs follow their commands non-inverted, with a single clock of latency on each channel. The block adds a guard interval whenever the leg commutes faster than the configured minimum, and it turns both switches off when both commands ask for conduction at once.

Any gate turning off, and reset itself, restarts a down-counter loaded with `DT_CYCLES`. Neither gate may turn on until that count has run out. A command for the other side that arrives during the count is held pending. It is granted when the count expires, but only if it is still asserted alone at that moment. A commanded gap longer than the minimum passes through unchanged. Because both directions use the same counter and the same path, the high-to-low and low-to-high dead times are equal to the cycle. A three-phase driver uses three instances.

Top module: `deadtime_interlock`

## Requirements
- R1: While `rst_n` is low, both gates are 0 one clock after each sampling edge, whatever the commands are.
- R2: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R3: When `cmd_hi` and `cmd_lo` are both 1 at a clock edge, both gates are 0 after that edge.
- R4: After any gate turns off, neither gate turns on until both gates have been 0 for at least `DT_CYCLES` consecutive cycles.
- R5: When the count has expired and the opposite gate is off, a lone command (hi=1, lo=0 or hi=0, lo=1) turns on its own gate after exactly one clock. The latency is the same on both channels.
- R6: If the opposite command drops at least `DT_CYCLES` cycles before a command rises, the gate turns on one clock after its command. The commanded gap is preserved.
- R7: If the opposite command drops fewer than `DT_CYCLES` cycles before a command rises, the gate turns on exactly `DT_CYCLES` clocks after the opposite gate turned off. This holds equally for high-to-low and low-to-high commutation.
- R8: A pending command that is withdrawn, or joined by the opposite command, before the count expires is not granted.
- R9: A command falling to 0 turns its gate off after one clock, with no added delay.
- R10: After reset is released, the first turn-on occurs no earlier than `DT_CYCLES` clocks after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_hi | input | 1 | Filtered high-side on command |
| cmd_lo | input | 1 | Filtered low-side on command |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The bench drives zero-gap commutations in both directions and checks that each waits the same count. A design with an off-by-one in the ready test, or one that reloads on only one side, would show unequal or short dead times. Gaps exactly at the minimum and well above it must pass without added delay; a design that always inserts the full interval would stretch them. Pending commands that are withdrawn or overlapped before expiry must never fire; a design that latches the request would fire a gate late. Reset in mid-conduction must drop the outputs at once and also restart the guard interval.

// File: rtl/dti_pkg.sv
// Shared definitions for the dead-time interlock.
// Assumes two sides per leg, indexed as below.
package dti_pkg;
    localparam int NUM_SIDES = 2;
    localparam int SIDE_HI   = 0;
    localparam int SIDE_LO   = 1;

    // Width needed to hold a count up to max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/dti_dead_counter.sv
// Guard-interval counter. It reloads to DT_CYCLES on restart or reset and counts
// down to zero. `ready` is high when the next edge may turn a gate on.
// Assumes DT_CYCLES >= 1.
module dti_dead_counter #(
    parameter int DT_CYCLES = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ready
);
    localparam int CW = dti_pkg::cnt_width(DT_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(DT_CYCLES);

    logic [CW-1:0] cnt_q;

    // Reload on any gate turn-off; otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= LOAD;
        else if (restart)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // A turn-on lands on the edge where the count reaches zero.
    assign ready = (cnt_q <= CW'(1));

    generate
        if (DT_CYCLES > 1) begin : g_reload_chk
            AST_RELOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !ready); // R4
        end
    endgenerate
endmodule

// File: rtl/dti_gate_side.sv
// One gate of the leg. It turns on when its own command is alone, the guard
// count is ready and the opposite gate is off. It stays on while its command
// stays alone. `fell` flags a turn-off at the coming edge.
module dti_gate_side (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_own,
    input  logic cmd_opp,
    input  logic gate_opp,
    input  logic ready,
    output logic gate,
    output logic fell
);
    logic alone;
    logic gate_nxt;

    // Decide the next gate state from the commands and the interlock.
    always_comb begin
        alone    = cmd_own & ~cmd_opp;
        gate_nxt = alone & (gate | (ready & ~gate_opp));
        fell     = gate & ~gate_nxt;
    end

    // Register the gate; reset holds it off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate <= 1'b0;
        else
            gate <= gate_nxt;
    end

    AST_OFF_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_own |=> !gate); // R9
endmodule

// File: rtl/deadtime_interlock.sv
// Dead-time and cross-conduction interlock for one half bridge.
// Inputs are assumed already filtered and synchronous to clk. Outputs are
// registered, with one clock of latency on both channels.
module deadtime_interlock #(
    parameter int DT_CYCLES = 72
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    output logic gate_hi,
    output logic gate_lo
);
    import dti_pkg::*;

    localparam int CW = cnt_width(DT_CYCLES);

    logic [NUM_SIDES-1:0] cmd_v;
    logic [NUM_SIDES-1:0] gate_v;
    logic [NUM_SIDES-1:0] fell_v;
    logic                 restart;
    logic                 ready;

    // Map the ports onto the per-side vectors.
    always_comb begin
        cmd_v[SIDE_HI] = cmd_hi;
        cmd_v[SIDE_LO] = cmd_lo;
        restart        = |fell_v;
    end

    assign gate_hi = gate_v[SIDE_HI];
    assign gate_lo = gate_v[SIDE_LO];

    dti_dead_counter #(.DT_CYCLES(DT_CYCLES)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ready   (ready)
    );

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            dti_gate_side u_side (
                .clk      (clk),
                .rst_n    (rst_n),
                .cmd_own  (cmd_v[s]),
                .cmd_opp  (cmd_v[NUM_SIDES-1-s]),
                .gate_opp (gate_v[NUM_SIDES-1-s]),
                .ready    (ready),
                .gate     (gate_v[s]),
                .fell     (fell_v[s])
            );
        end
    endgenerate

    // Checker state: consecutive cycles with both gates off, saturating.
    logic [CW-1:0] off_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_run_q <= '0;
        else if (gate_hi | gate_lo)
            off_run_q <= '0;
        else if (off_run_q != CW'(DT_CYCLES))
            off_run_q <= off_run_q + 1'b1;
    end

    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> (!gate_hi && !gate_lo)); // R1
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R2
    AST_BOTH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hi && cmd_lo) |=> (!gate_hi && !gate_lo)); // R3
    AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> (off_run_q >= CW'(DT_CYCLES))); // R4
    AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> (off_run_q >= CW'(DT_CYCLES))); // R4
endmodule

// File: tb/deadtime_interlock_tb_top.sv
module deadtime_interlock_tb_top;
    localparam int DT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_hi = 1'b0;
    logic cmd_lo = 1'b0;
    logic gate_hi;
    logic gate_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    deadtime_interlock #(.DT_CYCLES(DT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    typedef struct packed {
        logic        hi;
        logic        lo;
        logic [7:0]  len;
        logic        ehi;
        logic        elo;
        logic [23:0] tag;
    } seg_t;

    // Segments of constant command and constant expected output, DT = 8.
    // Cycle 0 is the first edge after reset release.
    localparam seg_t SEGS [20] = '{
        '{1'b1, 1'b0, 8'd7,  1'b0, 1'b0, "R10"}, // first turn-on waits
        '{1'b1, 1'b0, 8'd5,  1'b1, 1'b0, "R5"},
        '{1'b0, 1'b1, 8'd8,  1'b0, 1'b0, "R7"},  // hi->lo zero gap
        '{1'b0, 1'b1, 8'd5,  1'b0, 1'b1, "R7"},
        '{1'b1, 1'b0, 8'd8,  1'b0, 1'b0, "R7"},  // lo->hi zero gap
        '{1'b1, 1'b0, 8'd4,  1'b1, 1'b0, "R7"},
        '{1'b0, 1'b0, 8'd10, 1'b0, 1'b0, "R9"},
        '{1'b0, 1'b1, 8'd3,  1'b0, 1'b1, "R6"},  // gap 10 > DT
        '{1'b0, 1'b0, 8'd8,  1'b0, 1'b0, "R9"},
        '{1'b1, 1'b0, 8'd3,  1'b1, 1'b0, "R6"},  // gap exactly DT
        '{1'b1, 1'b1, 8'd3,  1'b0, 1'b0, "R3"},
        '{1'b0, 1'b1, 8'd5,  1'b0, 1'b0, "R4"},
        '{1'b0, 1'b1, 8'd2,  1'b0, 1'b1, "R4"},
        '{1'b1, 1'b0, 8'd3,  1'b0, 1'b0, "R8"},  // pending hi
        '{1'b0, 1'b0, 8'd6,  1'b0, 1'b0, "R8"},  // withdrawn before expiry
        '{1'b1, 1'b0, 8'd2,  1'b1, 1'b0, "R5"},
        '{1'b0, 1'b1, 8'd3,  1'b0, 1'b0, "R8"},  // pending lo
        '{1'b1, 1'b1, 8'd7,  1'b0, 1'b0, "R3"},  // overlapped past expiry
        '{1'b0, 1'b0, 8'd2,  1'b0, 1'b0, "R8"},
        '{1'b1, 1'b0, 8'd2,  1'b1, 1'b0, "R5"}
    };

    task automatic check(input logic ah, input logic al, input logic eh,
                         input logic el, input logic [23:0] tag);
        checks++;
        if (ah !== eh || al !== el) begin
            fails++;
            $display("FAIL %s: gate_hi/lo = %b%b, expected %b%b at %0t",
                     tag, ah, al, eh, el, $time);
        end
    endtask

    initial begin
        // R1: outputs off while in reset with conflicting stimulus.
        cmd_hi = 1'b1;
        repeat (2) @(posedge clk);
        #1 check(gate_hi, gate_lo, 1'b0, 1'b0, "R1");

        @(negedge clk);
        rst_n = 1'b1;
        foreach (SEGS[k]) begin
            for (int c = 0; c < int'(SEGS[k].len); c++) begin
                if (k != 0 || c != 0) @(negedge clk);
                cmd_hi = SEGS[k].hi;
                cmd_lo = SEGS[k].lo;
                @(posedge clk);
                #1;
                check(gate_hi, gate_lo, SEGS[k].ehi, SEGS[k].elo, SEGS[k].tag);
                checks++;
                if (gate_hi && gate_lo) begin
                    fails++;
                    $display("FAIL R2: gate_hi/lo = 11, expected not both");
                end
            end
        end

        // R1: reset during conduction drops the gate at once.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 check(gate_hi, gate_lo, 1'b0, 1'b0, "R1");
        @(negedge clk);
        cmd_hi = 1'b0;
        cmd_lo = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        // R10: low side stays off DT-1 edges, then turns on.
        for (int c = 0; c < DT + 2; c++) begin
            if (c != 0) @(negedge clk);
            @(posedge clk);
            #1 check(gate_hi, gate_lo, 1'b0, (c >= DT - 1), "R10");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule